// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits between two independent access ports (left and right) and a shared memory array. Each clock cycle it checks whether both ports are enabled on the same address. When they are, it picks one port as the owner of that location. It signals BUSY, active low, to the other port and blocks that port's write enable towards the array. The memory array itself is not part of this block, and neither is analog timing.

A strap input selects the role of the device. In master mode the block arbitrates on its own and drives its BUSY lines out. In slave mode it drives no BUSY and instead takes BUSY from an external master. This lets several devices work side by side to widen the data bus, all obeying one decision. In both modes a write towards the array is allowed only when the port's effective BUSY is inactive.

Arrival order is judged at clock granularity. A port counts as already present if it was enabled on the same address in the previous cycle. The setup window is therefore one clock.

Top module: `dp_contention_arb`

## Requirements
- R1: In master mode, contention exists only when `l_en` and `r_en` are both 1 and `l_addr` equals `r_addr`. Without contention, both `l_busy_n_o` and `r_busy_n_o` are 1.
- R2: In master mode, when contention starts and neither port was present before, the left port wins. In that case `r_busy_n_o` is 0 and `l_busy_n_o` is 1 in that same cycle. A port is present if it was enabled on the same address in the previous cycle. Neither port being present includes both ports becoming enabled on the same address in the same cycle.
- R3: In master mode, when contention starts and exactly one port is present, that port wins. A port is present if it was enabled on the same address in the previous cycle. The newly arriving port sees its BUSY at 0 in the first cycle of contention.
- R4: Once a winner is chosen, it stays the winner for every cycle that contention continues. BUSY returns to 1 in the first cycle without contention.
- R5: At most one of `l_busy_n_o` and `r_busy_n_o` is 0 in any cycle.
- R6: In master mode, a port's write enable to the array, `x_mem_we`, equals `x_en & x_wr & x_busy_n_o`. The losing port therefore cannot write.
- R7: In slave mode (`master_mode` = 0), `l_busy_n_o` and `r_busy_n_o` are both held at 1.
- R8: In slave mode, `x_mem_we` equals `x_en & x_wr & x_busy_n_i`. A write is inhibited while the external BUSY input is 0.
- R9: In master mode, the `x_busy_n_i` inputs have no effect on any output.
- R10: While `rst` is 1, both BUSY outputs are 1 and both write enables are 0. After reset, neither port counts as present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1: arbitrate locally and drive BUSY; 0: take BUSY from inputs |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write request |
| l_addr | input | ADDR_W | Left port address |
| l_busy_n_i | input | 1 | External BUSY for left port (slave mode), active low |
| l_busy_n_o | output | 1 | BUSY to left port (master mode), active low |
| l_mem_we | output | 1 | Gated left write enable to array |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write request |
| r_addr | input | ADDR_W | Right port address |
| r_busy_n_i | input | 1 | External BUSY for right port (slave mode), active low |
| r_busy_n_o | output | 1 | BUSY to right port (master mode), active low |
| r_mem_we | output | 1 | Gated right write enable to array |

## Verification
The start of contention and the choice of its winner fall in the same cycle. That cycle also decides whether the loser's write is blocked. The bench provokes this by enabling both ports on one address in one cycle, and also by letting one port arrive a cycle later, including by moving its address onto the other port's address. A per-cycle model, built from the requirements, predicts the winner, both BUSY lines and both write enables, and is compared before every clock edge. Mode changes with external BUSY held low are also exercised, to separate the two BUSY sources.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic busy;   // active-high internal form
        logic we;
    } port_out_s;

    localparam int NUM_PORTS = 2;

    // Decide the owner at the start of contention from who was already present.
    function automatic owner_e first_arrival(input logic l_present, input logic r_present);
        if (r_present && !l_present)
            return OWN_RIGHT;
        return OWN_LEFT;
    endfunction

endpackage

// File: rtl/arb_port_track.sv
module arb_port_track #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              present
);
    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    assign present = en && en_q && (addr == addr_q);
endmodule

// File: rtl/arb_owner.sv
module arb_owner
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clash,
    input  logic   l_present,
    input  logic   r_present,
    output owner_e winner
);
    owner_e owner_q;

    always_comb begin
        if (owner_q != OWN_NONE)
            winner = owner_q;
        else
            winner = first_arrival(l_present, r_present);
        if (!clash)
            winner = OWN_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            owner_q <= OWN_NONE;
        else
            owner_q <= winner;
    end
endmodule

// File: rtl/arb_port_gate.sv
module arb_port_gate
    import arb_pkg::*;
(
    input  logic      rst,
    input  logic      master_mode,
    input  logic      lost,
    input  logic      busy_n_i,
    input  logic      en,
    input  logic      wr,
    output logic      busy_n_o,
    output port_out_s status
);
    always_comb begin
        status.busy = master_mode ? lost : !busy_n_i;
        status.we   = en && wr && !status.busy;
        busy_n_o    = !(master_mode && lost);
        if (rst) begin
            status.we = 1'b0;
            busy_n_o  = 1'b1;
        end
    end
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
    import arb_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n_i,
    output logic              l_busy_n_o,
    output logic              l_mem_we,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n_i,
    output logic              r_busy_n_o,
    output logic              r_mem_we
);
    logic [NUM_PORTS-1:0]              en_v, wr_v, bsy_in_v, bsy_out_v, present_v, lost_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_v;
    port_out_s [NUM_PORTS-1:0]         st_v;
    logic                              clash;
    owner_e                            winner;

    assign en_v     = {r_en, l_en};
    assign wr_v     = {r_wr, l_wr};
    assign bsy_in_v = {r_busy_n_i, l_busy_n_i};
    assign addr_v   = {r_addr, l_addr};

    assign clash = l_en && r_en && (l_addr == r_addr);

    assign lost_v[0] = (winner == OWN_RIGHT);
    assign lost_v[1] = (winner == OWN_LEFT);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        arb_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk     (clk),
            .rst     (rst),
            .en      (en_v[p]),
            .addr    (addr_v[p]),
            .present (present_v[p])
        );
        arb_port_gate u_gate (
            .rst         (rst),
            .master_mode (master_mode),
            .lost        (lost_v[p]),
            .busy_n_i    (bsy_in_v[p]),
            .en          (en_v[p]),
            .wr          (wr_v[p]),
            .busy_n_o    (bsy_out_v[p]),
            .status      (st_v[p])
        );
    end

    arb_owner u_owner (
        .clk       (clk),
        .rst       (rst),
        .clash     (clash),
        .l_present (present_v[0]),
        .r_present (present_v[1]),
        .winner    (winner)
    );

    assign l_busy_n_o = bsy_out_v[0];
    assign r_busy_n_o = bsy_out_v[1];
    assign l_mem_we   = st_v[0].we;
    assign r_mem_we   = st_v[1].we;
endmodule

// File: rtl/dp_contention_arb_chk.sv
module dp_contention_arb_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              master_mode,
    input logic              l_en,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_n_i,
    input logic              l_busy_n_o,
    input logic              l_mem_we,
    input logic              r_en,
    input logic              r_wr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_n_i,
    input logic              r_busy_n_o,
    input logic              r_mem_we
);
    logic match;
    assign match = l_en && r_en && (l_addr == r_addr);

    // R5
    one_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_n_o && !r_busy_n_o));

    // R7
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> (l_busy_n_o && r_busy_n_o));

    // R1
    no_clash_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !match) |-> (l_busy_n_o && r_busy_n_o));

    // R2
    tie_left_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && match && !$past(l_en) && !$past(r_en)) |-> (!r_busy_n_o && l_busy_n_o));

    // R4
    hold_right_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && match && $past(master_mode && match && !r_busy_n_o)) |-> !r_busy_n_o);

    // R6
    loser_write_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !r_busy_n_o) |-> !r_mem_we);

    // R8
    slave_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && !l_busy_n_i) |-> !l_mem_we);

    // R10
    always_comb begin
        if (rst) begin
            reset_quiet_chk: assert (l_busy_n_o && r_busy_n_o && !l_mem_we && !r_mem_we);
        end
    end
endmodule

bind dp_contention_arb dp_contention_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dp_contention_arb_bench.sv
module dp_contention_arb_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;

    logic clk = 1'b0;
    logic rst, master_mode;
    logic l_en, l_wr, l_busy_n_i, r_en, r_wr, r_busy_n_i;
    logic [AW-1:0] l_addr, r_addr;
    logic l_busy_n_o, l_mem_we, r_busy_n_o, r_mem_we;

    int tests = 0;
    int fails = 0;

    // reference model state: 0 none, 1 left, 2 right
    int m_owner = 0;
    bit m_l_en_q = 0, m_r_en_q = 0;
    logic [AW-1:0] m_l_a_q = '0, m_r_a_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_contention_arb #(.ADDR_W(AW)) u_dp_contention_arb (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr), .l_busy_n_i(l_busy_n_i),
        .l_busy_n_o(l_busy_n_o), .l_mem_we(l_mem_we),
        .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr), .r_busy_n_i(r_busy_n_i),
        .r_busy_n_o(r_busy_n_o), .r_mem_we(r_mem_we)
    );

    task automatic cmp(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input string req, input bit rs, input bit ms,
                        input bit le, input bit lw, input int la, input bit lbi,
                        input bit re, input bit rw, input int ra, input bit rbi);
        bit match, lp, rp, eb_l, eb_r, xb_l, xb_r, xw_l, xw_r;
        int win;
        @(negedge clk);
        rst = rs; master_mode = ms;
        l_en = le; l_wr = lw; l_addr = AW'(la); l_busy_n_i = lbi;
        r_en = re; r_wr = rw; r_addr = AW'(ra); r_busy_n_i = rbi;
        #1;
        match = le && re && (AW'(la) == AW'(ra));
        lp = le && m_l_en_q && (AW'(la) == m_l_a_q);
        rp = re && m_r_en_q && (AW'(ra) == m_r_a_q);
        if (!match) win = 0;
        else if (m_owner != 0) win = m_owner;
        else if (rp && !lp) win = 2;
        else win = 1;
        if (ms) begin
            eb_l = (win == 2); eb_r = (win == 1);
            xb_l = !eb_l; xb_r = !eb_r;
        end else begin
            eb_l = !lbi; eb_r = !rbi;
            xb_l = 1; xb_r = 1;
        end
        xw_l = le && lw && !eb_l;
        xw_r = re && rw && !eb_r;
        if (rs) begin xb_l = 1; xb_r = 1; xw_l = 0; xw_r = 0; end
        cmp(req, "l_busy_n_o", l_busy_n_o, xb_l);
        cmp(req, "r_busy_n_o", r_busy_n_o, xb_r);
        cmp(req, "l_mem_we", l_mem_we, xw_l);
        cmp(req, "r_mem_we", r_mem_we, xw_r);
        @(posedge clk);
        if (rs) begin
            m_owner = 0; m_l_en_q = 0; m_r_en_q = 0; m_l_a_q = '0; m_r_a_q = '0;
        end else begin
            m_owner = win;
            m_l_en_q = le; m_r_en_q = re; m_l_a_q = AW'(la); m_r_a_q = AW'(ra);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R10: reset, even with a clash and write requests present
        step("R10", 1, 1, 1, 1, 5, 1, 1, 1, 5, 1);
        step("R10", 1, 1, 1, 1, 5, 1, 1, 1, 5, 1);
        // R1: different addresses, or one port disabled
        step("R1", 0, 1, 1, 1, 3, 1, 1, 1, 4, 1);
        step("R1", 0, 1, 1, 1, 7, 1, 0, 1, 7, 1);
        step("R1", 0, 1, 0, 0, 0, 1, 0, 0, 0, 1);
        // R2 / R6: same-cycle arrival, left wins, right write blocked
        step("R2", 0, 1, 1, 1, 9, 1, 1, 1, 9, 1);
        // R4: winner kept while contention lasts
        step("R4", 0, 1, 1, 1, 9, 1, 1, 1, 9, 1);
        step("R4", 0, 1, 1, 0, 9, 1, 1, 1, 9, 1);
        step("R4", 0, 1, 1, 1, 2, 1, 1, 1, 9, 1);
        step("R1", 0, 1, 0, 0, 0, 1, 0, 0, 0, 1);
        // R3: right present first, left arrives later
        step("R3", 0, 1, 0, 0, 0, 1, 1, 0, 20, 1);
        step("R3", 0, 1, 1, 1, 20, 1, 1, 1, 20, 1);
        step("R4", 0, 1, 1, 1, 20, 1, 1, 1, 20, 1);
        step("R4", 0, 1, 1, 1, 20, 1, 0, 1, 20, 1);
        // R3: left moves its address onto the right port's location
        step("R3", 0, 1, 1, 1, 30, 1, 1, 1, 31, 1);
        step("R3", 0, 1, 1, 1, 31, 1, 1, 1, 31, 1);
        step("R6", 0, 1, 1, 1, 31, 1, 1, 1, 31, 1);
        // R3: left present first
        step("R3", 0, 1, 1, 0, 40, 1, 0, 0, 0, 1);
        step("R3", 0, 1, 1, 1, 40, 1, 1, 1, 40, 1);
        step("R1", 0, 1, 0, 0, 0, 1, 0, 0, 0, 1);
        // R9: external BUSY inputs low in master mode have no effect
        step("R9", 0, 1, 1, 1, 50, 0, 1, 1, 51, 0);
        step("R9", 0, 1, 1, 1, 52, 0, 1, 1, 52, 0);
        step("R9", 0, 1, 1, 1, 52, 0, 1, 1, 52, 0);
        step("R1", 0, 1, 0, 0, 0, 1, 0, 0, 0, 1);
        // R7 / R8: slave mode uses external BUSY
        step("R7", 0, 0, 1, 1, 60, 1, 1, 1, 60, 1);
        step("R8", 0, 0, 1, 1, 60, 0, 1, 1, 60, 1);
        step("R8", 0, 0, 1, 1, 60, 1, 1, 1, 61, 0);
        step("R8", 0, 0, 1, 1, 62, 0, 1, 1, 63, 0);
        step("R7", 0, 0, 1, 0, 64, 1, 1, 1, 64, 1);
        // back to master mode, then a final reset
        step("R1", 0, 1, 0, 0, 0, 1, 0, 0, 0, 1);
        step("R2", 0, 1, 1, 1, 70, 1, 1, 1, 70, 1);
        step("R10", 1, 1, 1, 1, 70, 1, 1, 1, 70, 1);
        step("R2", 0, 1, 1, 1, 70, 1, 1, 1, 70, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule